// File: doc/BRIEF.md
# Eight-Instruction Accumulator Processor Core

This block is a compact 8-bit processor built around one accumulator. It fetches each 16-bit instruction as two bytes over a shared bidirectional byte bus and a 13-bit address bus. Every operand is addressed directly by the 13-bit field of the instruction. The core holds the program counter, the instruction register, the accumulator and the operation logic, together with the sequencer that steps each instruction through its bus phases.

Program memory, data memory and any address decoding sit outside the block. They see only the address, the read and write strobes and the byte bus. External storage drives the bus while the read strobe is high. It captures the bus on the rising clock edge while the write strobe is high. The core drives the bus only during a store.

Top module: `acc_cpu`

## Requirements
- R1: While reset is low, the core presents address 0000 with fetch and rd high, and wr and halt low. After reset is released, execution begins at address 0000.
- R2: Every instruction is read as two bytes. The first byte comes from the even program-counter address and the second from that address plus one, and fetch is high in both cycles. The first byte carries the opcode in bits 7:5 and target address bits 12:8 in bits 4:0. The second byte carries target bits 7:0.
- R3: The opcode encoding is 000 halt, 001 skip-if-zero, 010 add, 011 and, 100 xor, 101 load, 110 store, 111 jump.
- R4: Load reads the byte at the target address into the accumulator.
- R5: Add puts the low 8 bits of accumulator plus memory byte into the accumulator, so FF plus 01 gives 00.
- R6: And and xor combine the accumulator bitwise with the memory byte at the target address, and the result goes to the accumulator.
- R7: Store drives the accumulator onto the data bus with wr high and rd low for one cycle, with the target on the address bus.
- R8: Jump makes the next instruction fetch start at the target address.
- R9: Skip-if-zero moves on to the instruction 4 bytes later when the accumulator is zero, and to the next instruction (2 bytes later) otherwise.
- R10: Halt raises the halt output, which then stays high with rd, wr and fetch low until reset.
- R11: rd and wr are never high together, and when wr is low the core does not drive the data bus.
- R12: Every instruction, halt included, takes exactly three clock cycles: high-byte fetch, low-byte fetch, then one operand phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | output | 13 | Memory address |
| data | inout | 8 | Shared byte bus, driven by the core only during a store |
| rd | output | 1 | Read strobe; memory drives the bus while high |
| wr | output | 1 | Write strobe; memory captures the bus at the clock edge |
| fetch | output | 1 | High in the two instruction-fetch cycles |
| halt | output | 1 | High once a halt instruction has executed |

## Verification
Each instruction takes three cycles, so the bench counts rising edges from reset release to the first falling edge that shows halt high. A program of N instructions must give exactly 3N. Bus behaviour is checked every cycle at the falling edge, after the address and strobes of that cycle have settled: the strobes, the high-impedance bus and the low-byte fetch address. The log of high-byte fetch addresses kept there gives the control-flow path of jumps and skips. Accumulator results go out through stores, which land in bench memory at the edge that ends the operand phase. They are read only after halt, so no check samples a value before the cycle in which it is written.

// File: rtl/acc_cpu.sv
module acc_cpu #(
  parameter int DW = 8,
  parameter int AW = 13,
  parameter int OPW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] addr,
  inout  wire  [DW-1:0] data,
  output logic          rd,
  output logic          wr,
  output logic          fetch,
  output logic          halt
);
  localparam int HIW = AW - DW;

  typedef enum logic [OPW-1:0] {
    OP_HLT = 3'b000, OP_SKZ = 3'b001, OP_ADD = 3'b010, OP_AND = 3'b011,
    OP_XOR = 3'b100, OP_LDA = 3'b101, OP_STO = 3'b110, OP_JMP = 3'b111
  } op_t;

  typedef enum logic [1:0] {ST_HI, ST_LO, ST_EX, ST_STOP} st_t;

  st_t           st;
  logic [AW-1:0] pc;
  logic [DW-1:0] ir_hi, ir_lo, acc;
  op_t           op;
  logic [AW-1:0] tgt;
  logic          mem_rd;

  assign op     = op_t'(ir_hi[DW-1 -: OPW]);
  assign tgt    = {ir_hi[HIW-1:0], ir_lo};
  assign mem_rd = (op == OP_ADD) || (op == OP_AND) || (op == OP_XOR) || (op == OP_LDA);

  assign fetch = (st == ST_HI) || (st == ST_LO);
  assign halt  = (st == ST_STOP);
  assign rd    = fetch || (st == ST_EX && mem_rd);
  assign wr    = (st == ST_EX) && (op == OP_STO);
  assign data  = wr ? acc : {DW{1'bz}};

  always_comb begin
    case (st)
      ST_HI:   addr = pc;
      ST_LO:   addr = pc + AW'(1);
      ST_EX:   addr = tgt;
      default: addr = pc;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_HI;
      pc    <= '0;
      ir_hi <= '0;
      ir_lo <= '0;
      acc   <= '0;
    end else begin
      case (st)
        ST_HI: begin
          ir_hi <= data;
          st    <= ST_LO;
        end
        ST_LO: begin
          ir_lo <= data;
          pc    <= pc + AW'(2);
          st    <= ST_EX;
        end
        ST_EX: begin
          st <= ST_HI;
          case (op)
            OP_HLT: st  <= ST_STOP;
            OP_SKZ: if (acc == '0) pc <= pc + AW'(2);
            OP_ADD: acc <= acc + data;
            OP_AND: acc <= acc & data;
            OP_XOR: acc <= acc ^ data;
            OP_LDA: acc <= data;
            OP_JMP: pc  <= tgt;
            default: ;
          endcase
        end
        default: st <= ST_STOP;
      endcase
    end
  end

  assert_rd_wr_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd && wr));

  assert_store_phase_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr |-> (!fetch && !rd && data == acc));

  assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> halt);

  assert_halt_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> (!rd && !wr && !fetch));

  assert_lo_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch && !addr[0]) |=> (fetch && addr == $past(addr) + AW'(1)));

  assert_three_phase_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch && addr[0]) |=> !fetch);

  assert_next_fetch_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch && !halt) |=> (fetch || halt));
endmodule

// File: tb/acc_cpu_tb.sv
`timescale 1ns/1ps
module acc_cpu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] addr;
  wire  [7:0]  bus;
  logic        rd, wr, fetch, halt;

  int checks = 0;
  int fails  = 0;

  logic [7:0]  mem [0:511];
  logic [12:0] trace [0:63];
  int          tn = 0;
  int          bus_viol = 0;
  int          lo_viol = 0;
  int          quiet_viol = 0;
  logic [12:0] last_even = '0;
  wire  [8:0]  midx = {addr[12], addr[7:0]};

  always #2.5 clk = ~clk;

  acc_cpu u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .data(bus),
    .rd(rd), .wr(wr), .fetch(fetch), .halt(halt)
  );

  assign bus = rd ? mem[midx] : 8'hzz;

  always @(posedge clk) if (wr) mem[midx] <= bus;

  always @(negedge clk) begin
    if (rst_n) begin
      if (rd && wr) bus_viol++;
      if (!wr && !rd && bus !== 8'hzz) bus_viol++;
      if (halt && (rd || wr || fetch)) quiet_viol++;
      if (fetch && !addr[0]) begin
        last_even = addr;
        if (tn < 64) trace[tn] = addr;
        tn++;
      end
      if (fetch && addr[0] && addr != last_even + 13'd1) lo_viol++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 512; i++) mem[i] = 8'h00;
  endtask

  function automatic int ix(input logic [12:0] a);
    return {23'd0, a[12], a[7:0]};
  endfunction

  task automatic put(input logic [12:0] a, input logic [2:0] op, input logic [12:0] t);
    mem[ix(a)]     = {op, t[12:8]};
    mem[ix(a) + 1] = t[7:0];
  endtask

  task automatic run(input string tag, input int n_instr);
    int cyc;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 addr", 32'(addr), 32'h0);
    chk("R1 strobes", {28'd0, fetch, rd, wr, halt}, 32'b1100);
    tn = 0; bus_viol = 0; lo_viol = 0; quiet_viol = 0;
    rst_n = 1'b1;
    cyc = 0;
    while (!halt && cyc < 1000) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
    end
    // R12: three cycles per instruction
    chk({tag, " R12 cycles"}, 32'(cyc), 32'(3 * n_instr));
    repeat (10) @(negedge clk);
    // R10: halt stays, bus quiet
    chk({tag, " R10 halt"}, {31'd0, halt}, 32'd1);
    chk({tag, " R10 quiet"}, 32'(quiet_viol), 32'd0);
    chk({tag, " R11 bus"}, 32'(bus_viol), 32'd0);
    chk({tag, " R2 lo fetch"}, 32'(lo_viol), 32'd0);
  endtask

  task automatic test_alu();
    clear_mem();
    mem[ix(13'h1800)] = 8'h5A;
    mem[ix(13'h1801)] = 8'h0F;
    mem[ix(13'h1802)] = 8'hFF;
    mem[ix(13'h1803)] = 8'h01;
    put(13'h00, 3'b101, 13'h1800);
    put(13'h02, 3'b011, 13'h1801);
    put(13'h04, 3'b110, 13'h1810);
    put(13'h06, 3'b100, 13'h1802);
    put(13'h08, 3'b110, 13'h1811);
    put(13'h0A, 3'b101, 13'h1802);
    put(13'h0C, 3'b010, 13'h1803);
    put(13'h0E, 3'b110, 13'h1812);
    put(13'h10, 3'b010, 13'h1801);
    put(13'h12, 3'b110, 13'h1813);
    put(13'h14, 3'b101, 13'h1800);
    put(13'h16, 3'b110, 13'h1814);
    put(13'h18, 3'b000, 13'h0000);
    run("alu", 13);
    chk("R6 and", 32'(mem[ix(13'h1810)]), 32'h0A);
    chk("R6 xor", 32'(mem[ix(13'h1811)]), 32'hF5);
    chk("R5 add wrap", 32'(mem[ix(13'h1812)]), 32'h00);
    chk("R5 add", 32'(mem[ix(13'h1813)]), 32'h0F);
    chk("R4 R7 load store", 32'(mem[ix(13'h1814)]), 32'h5A);
    chk("R3 R7 source kept", 32'(mem[ix(13'h1800)]), 32'h5A);
  endtask

  task automatic test_flow();
    logic [12:0] exp [0:6];
    exp = '{13'h00, 13'h02, 13'h06, 13'h20, 13'h22, 13'h24, 13'h30};
    clear_mem();
    mem[ix(13'h1800)] = 8'h00;
    mem[ix(13'h1803)] = 8'h01;
    put(13'h00, 3'b101, 13'h1800);
    put(13'h02, 3'b001, 13'h0000);
    put(13'h04, 3'b111, 13'h0040);
    put(13'h06, 3'b111, 13'h0020);
    put(13'h20, 3'b101, 13'h1803);
    put(13'h22, 3'b001, 13'h0000);
    put(13'h24, 3'b111, 13'h0030);
    put(13'h26, 3'b000, 13'h0000);
    put(13'h30, 3'b000, 13'h0000);
    put(13'h40, 3'b000, 13'h0000);
    run("flow", 7);
    chk("R8 R9 fetch count", 32'(tn), 32'd7);
    for (int i = 0; i < 7; i++) begin
      if (i == 3 || i == 6) chk("R8 jump target", 32'(trace[i]), 32'(exp[i]));
      else chk("R9 skip path", 32'(trace[i]), 32'(exp[i]));
    end
  endtask

  task automatic test_restart();
    clear_mem();
    put(13'h00, 3'b111, 13'h0010);
    put(13'h10, 3'b000, 13'h0000);
    run("restart", 2);
    chk("R1 start address", 32'(trace[0]), 32'h0);
    chk("R8 jump far", 32'(trace[1]), 32'h10);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    test_alu();
    test_flow();
    test_restart();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule